// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block chooses where each operand of a five-stage pipeline comes from when an older instruction has produced a value that has not yet reached the register file. It serves two consumer points. The first is the pair of ALU operands in the execute stage. The second is the pair of equality-comparator operands in the decode stage, where branches are resolved.

For every operand it compares the source register number against the destination numbers held in the EX/MEM and MEM/WB pipeline registers. It then emits a two-bit select code. A thin datapath applies those codes to the candidate values, so the forwarded operand values appear directly at the ports. The block is purely combinational.

Some dependencies cannot be covered by a bypass, such as a load feeding the very next instruction, or an ALU result feeding a branch one slot behind. Those are left to separate stall logic. This block only declines to forward in those cases.

Top module: `fwd_unit`

## Requirements
- R1: When the EX/MEM entry writes a register (write flag 1, memory-to-register flag 0), its destination is nonzero and it equals an execute-stage source, that operand's select is 2'b10 and its value is the EX/MEM ALU result.
- R2: When only the MEM/WB entry matches an execute-stage source, with write flag 1, nonzero destination and memory-to-register flag 0, the select is 2'b01 and the value is the MEM/WB ALU result.
- R3: Under the conditions of R2 but with the MEM/WB memory-to-register flag at 1, the select is 2'b01 and the value is the MEM/WB load data.
- R4: A decode-stage comparator operand whose register matches a qualifying EX/MEM ALU producer (as in R1) gets select 2'b10 and the EX/MEM ALU result.
- R5: When both EX/MEM and MEM/WB qualify for the same operand, EX/MEM is chosen (select 2'b10), at both consumer points.
- R6: A source register number of zero is never forwarded: its select is 2'b00 and its value is the register-file value.
- R7: A producer whose register-write flag is 0 is never forwarded from.
- R8: Each of the four operands is selected on its own, so two operands may be fed from different stages at the same time.
- R9: An EX/MEM entry with its memory-to-register flag at 1 (a load still in memory) is not forwarded. The operand falls back to MEM/WB if that qualifies, and otherwise to the register file.
- R10: With parameter WB_TO_ID = 1, a decode-stage operand matching only a qualifying MEM/WB producer gets select 2'b01 and the MEM/WB ALU result or load data, chosen by the memory-to-register flag.
- R11: With no qualifying match, the select is 2'b00 and the register-file value passes through. The code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exRsAddr | input | AW | First source register of the execute-stage instruction |
| exRtAddr | input | AW | Second source register of the execute-stage instruction |
| idRsAddr | input | AW | First source register of the decode-stage branch |
| idRtAddr | input | AW | Second source register of the decode-stage branch |
| memRd | input | AW | Destination register in EX/MEM |
| memRegWr | input | 1 | Register-write flag in EX/MEM |
| memMemToReg | input | 1 | Memory-to-register flag in EX/MEM |
| wbRd | input | AW | Destination register in MEM/WB |
| wbRegWr | input | 1 | Register-write flag in MEM/WB |
| wbMemToReg | input | 1 | Memory-to-register flag in MEM/WB |
| exRsRf | input | DW | Register-file value for exRsAddr |
| exRtRf | input | DW | Register-file value for exRtAddr |
| idRsRf | input | DW | Register-file value for idRsAddr |
| idRtRf | input | DW | Register-file value for idRtAddr |
| memAluRes | input | DW | ALU result held in EX/MEM |
| wbAluRes | input | DW | ALU result held in MEM/WB |
| wbLoadData | input | DW | Load data held in MEM/WB |
| exASel | output | 2 | Select for ALU operand A |
| exBSel | output | 2 | Select for ALU operand B |
| idASel | output | 2 | Select for comparator operand A |
| idBSel | output | 2 | Select for comparator operand B |
| exAVal | output | DW | Forwarded ALU operand A |
| exBVal | output | DW | Forwarded ALU operand B |
| idAVal | output | DW | Forwarded comparator operand A |
| idBVal | output | DW | Forwarded comparator operand B |

## Verification
Because the block holds no state, a wrong decision shows up in the same evaluation as the inputs that caused it. It appears as a select code that differs from the arithmetic expectation, or as an operand value taken from the wrong candidate. Every candidate value is distinct in the sweep, so a mux that follows the wrong code is told apart from a select that is itself wrong. The sweep walks every combination of source, destination and flags over a four-register configuration. This covers the priority, register-zero, write-disabled and pending-load corners at both consumer points.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwdSel_t;

  localparam int NUM_OPS = 4;
  // operand slots: 0 = execute A, 1 = execute B, 2 = decode A, 3 = decode B
  localparam int FIRST_ID_OP = 2;

  typedef struct packed {
    logic [NUM_OPS-1:0][1:0] sel;
    logic                    wbUseLoad;
  } fwdStrobes_t;
endpackage

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
#(
  parameter int AW       = 5,
  parameter bit WB_TO_ID = 1'b1
) (
  input  logic [NUM_OPS-1:0][AW-1:0] srcAddr,
  input  logic [AW-1:0]              memRd,
  input  logic                       memRegWr,
  input  logic                       memMemToReg,
  input  logic [AW-1:0]              wbRd,
  input  logic                       wbRegWr,
  input  logic                       wbMemToReg,
  output fwdStrobes_t                strobes
);
  logic memProducer;
  logic wbProducer;

  // a load sitting in EX/MEM carries an address, not its result
  assign memProducer = memRegWr && !memMemToReg && (memRd != '0);
  assign wbProducer  = wbRegWr && (wbRd != '0);

  generate
    for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
      localparam bit ALLOW_WB = (i < FIRST_ID_OP) ? 1'b1 : WB_TO_ID;
      logic memHit;
      logic wbHit;
      assign memHit = memProducer && (memRd == srcAddr[i]);
      assign wbHit  = ALLOW_WB && wbProducer && (wbRd == srcAddr[i]);
      always_comb begin
        if (memHit)     strobes.sel[i] = SEL_MEM;
        else if (wbHit) strobes.sel[i] = SEL_WB;
        else            strobes.sel[i] = SEL_RF;
      end
    end
  endgenerate

  assign strobes.wbUseLoad = wbMemToReg;
endmodule

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int DW = 32
) (
  input  fwdStrobes_t                strobes,
  input  logic [NUM_OPS-1:0][DW-1:0] rfVal,
  input  logic [DW-1:0]              memAluRes,
  input  logic [DW-1:0]              wbAluRes,
  input  logic [DW-1:0]              wbLoadData,
  output logic [NUM_OPS-1:0][DW-1:0] opVal
);
  logic [DW-1:0] wbVal;

  assign wbVal = strobes.wbUseLoad ? wbLoadData : wbAluRes;

  generate
    for (genvar i = 0; i < NUM_OPS; i++) begin : g_mux
      always_comb begin
        unique case (strobes.sel[i])
          SEL_MEM: opVal[i] = memAluRes;
          SEL_WB:  opVal[i] = wbVal;
          default: opVal[i] = rfVal[i];
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int AW       = 5,
  parameter int DW       = 32,
  parameter bit WB_TO_ID = 1'b1
) (
  input  logic [AW-1:0] exRsAddr,
  input  logic [AW-1:0] exRtAddr,
  input  logic [AW-1:0] idRsAddr,
  input  logic [AW-1:0] idRtAddr,
  input  logic [AW-1:0] memRd,
  input  logic          memRegWr,
  input  logic          memMemToReg,
  input  logic [AW-1:0] wbRd,
  input  logic          wbRegWr,
  input  logic          wbMemToReg,
  input  logic [DW-1:0] exRsRf,
  input  logic [DW-1:0] exRtRf,
  input  logic [DW-1:0] idRsRf,
  input  logic [DW-1:0] idRtRf,
  input  logic [DW-1:0] memAluRes,
  input  logic [DW-1:0] wbAluRes,
  input  logic [DW-1:0] wbLoadData,
  output logic [1:0]    exASel,
  output logic [1:0]    exBSel,
  output logic [1:0]    idASel,
  output logic [1:0]    idBSel,
  output logic [DW-1:0] exAVal,
  output logic [DW-1:0] exBVal,
  output logic [DW-1:0] idAVal,
  output logic [DW-1:0] idBVal
);
  fwdStrobes_t                strobes;
  logic [NUM_OPS-1:0][AW-1:0] srcAddr;
  logic [NUM_OPS-1:0][DW-1:0] rfVal;
  logic [NUM_OPS-1:0][DW-1:0] opVal;

  assign srcAddr = {idRtAddr, idRsAddr, exRtAddr, exRsAddr};
  assign rfVal   = {idRtRf, idRsRf, exRtRf, exRsRf};

  fwd_ctrl #(.AW(AW), .WB_TO_ID(WB_TO_ID)) u_ctrl (
    .srcAddr     (srcAddr),
    .memRd       (memRd),
    .memRegWr    (memRegWr),
    .memMemToReg (memMemToReg),
    .wbRd        (wbRd),
    .wbRegWr     (wbRegWr),
    .wbMemToReg  (wbMemToReg),
    .strobes     (strobes)
  );

  fwd_datapath #(.DW(DW)) u_dp (
    .strobes    (strobes),
    .rfVal      (rfVal),
    .memAluRes  (memAluRes),
    .wbAluRes   (wbAluRes),
    .wbLoadData (wbLoadData),
    .opVal      (opVal)
  );

  assign exASel = strobes.sel[0];
  assign exBSel = strobes.sel[1];
  assign idASel = strobes.sel[2];
  assign idBSel = strobes.sel[3];
  assign exAVal = opVal[0];
  assign exBVal = opVal[1];
  assign idAVal = opVal[2];
  assign idBVal = opVal[3];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input logic [AW-1:0] exRsAddr,
  input logic [AW-1:0] exRtAddr,
  input logic [AW-1:0] idRsAddr,
  input logic [AW-1:0] memRd,
  input logic          memRegWr,
  input logic          memMemToReg,
  input logic [AW-1:0] wbRd,
  input logic          wbRegWr,
  input logic          wbMemToReg,
  input logic [DW-1:0] exRsRf,
  input logic [DW-1:0] memAluRes,
  input logic [DW-1:0] wbAluRes,
  input logic [DW-1:0] wbLoadData,
  input logic [1:0]    exASel,
  input logic [1:0]    exBSel,
  input logic [1:0]    idASel,
  input logic [DW-1:0] exAVal,
  input logic [DW-1:0] idAVal
);
  always_comb begin
    AST_MEM_VALUE: assert (exASel != 2'b10 || exAVal == memAluRes); // R1
    AST_WB_ALU_VALUE: assert (exASel != 2'b01 || wbMemToReg || exAVal == wbAluRes); // R2
    AST_WB_LOAD_VALUE: assert (exASel != 2'b01 || !wbMemToReg || exAVal == wbLoadData); // R3
    AST_ID_MEM_VALUE: assert (idASel != 2'b10 || idAVal == memAluRes); // R4
    AST_NO_ZERO_FWD: assert (exRsAddr != '0 || exASel == 2'b00); // R6
    AST_MEM_NEEDS_WR: assert (exASel != 2'b10 || (memRegWr && !memMemToReg && memRd == exRsAddr)); // R9
    AST_WB_NEEDS_WR: assert (exBSel != 2'b01 || (wbRegWr && wbRd == exRtAddr)); // R7
    AST_WB_ID_MATCH: assert (idASel != 2'b01 || (wbRegWr && wbRd == idRsAddr)); // R10
    AST_RF_PASS: assert (exASel != 2'b00 || exAVal == exRsRf); // R11
    AST_NO_CODE3: assert (exASel != 2'b11 && exBSel != 2'b11 && idASel != 2'b11); // R11
  end
endmodule

bind fwd_unit fwd_unit_chk #(.AW(AW), .DW(DW)) u_chk (
  .exRsAddr    (exRsAddr),
  .exRtAddr    (exRtAddr),
  .idRsAddr    (idRsAddr),
  .memRd       (memRd),
  .memRegWr    (memRegWr),
  .memMemToReg (memMemToReg),
  .wbRd        (wbRd),
  .wbRegWr     (wbRegWr),
  .wbMemToReg  (wbMemToReg),
  .exRsRf      (exRsRf),
  .memAluRes   (memAluRes),
  .wbAluRes    (wbAluRes),
  .wbLoadData  (wbLoadData),
  .exASel      (exASel),
  .exBSel      (exBSel),
  .idASel      (idASel),
  .exAVal      (exAVal),
  .idAVal      (idAVal)
);

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb;
  localparam int AW  = 2;
  localparam int DW  = 16;
  localparam bit BYP = 1'b1;

  logic clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic [AW-1:0] exRsAddr, exRtAddr, idRsAddr, idRtAddr, memRd, wbRd;
  logic memRegWr, memMemToReg, wbRegWr, wbMemToReg;
  logic [DW-1:0] exRsRf, exRtRf, idRsRf, idRtRf, memAluRes, wbAluRes, wbLoadData;
  logic [1:0] exASel, exBSel, idASel, idBSel;
  logic [DW-1:0] exAVal, exBVal, idAVal, idBVal;

  int checks = 0;
  int failures = 0;

  fwd_unit #(.AW(AW), .DW(DW), .WB_TO_ID(BYP)) u_dut (.*);

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic [1:0] expSel(int src, bit idPoint);
    bit memOk, wbOk;
    memOk = memRegWr && !memMemToReg && memRd != 0 && int'(memRd) == src;
    wbOk  = wbRegWr && wbRd != 0 && int'(wbRd) == src && (!idPoint || BYP);
    if (memOk) return 2'b10;
    if (wbOk)  return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [DW-1:0] expVal(logic [1:0] s, logic [DW-1:0] rf);
    if (s == 2'b10) return memAluRes;
    if (s == 2'b01) return wbMemToReg ? wbLoadData : wbAluRes;
    return rf;
  endfunction

  function automatic string tagOf(int src, bit idPoint);
    bit memMatch, wbMatch;
    memMatch = int'(memRd) == src;
    wbMatch  = int'(wbRd) == src;
    if (src == 0) return "R6";
    if (memMatch && memRegWr && !memMemToReg && wbMatch && wbRegWr) return "R5";
    if (memMatch && memRegWr && !memMemToReg) return idPoint ? "R4" : "R1";
    if (memMatch && memRegWr && memMemToReg) return "R9";
    if (wbMatch && wbRegWr) return idPoint ? "R10" : (wbMemToReg ? "R3" : "R2");
    if ((memMatch && !memRegWr) || (wbMatch && !wbRegWr)) return "R7";
    return "R11";
  endfunction

  task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string forceTag);
    logic [1:0] s;
    @(negedge clk);
    s = expSel(int'(exRsAddr), 1'b0);
    chk(forceTag == "" ? tagOf(int'(exRsAddr), 1'b0) : forceTag, "exASel", DW'(exASel), DW'(s));
    chk(forceTag == "" ? tagOf(int'(exRsAddr), 1'b0) : forceTag, "exAVal", exAVal, expVal(s, exRsRf));
    s = expSel(int'(exRtAddr), 1'b0);
    chk(forceTag == "" ? tagOf(int'(exRtAddr), 1'b0) : forceTag, "exBSel", DW'(exBSel), DW'(s));
    chk(forceTag == "" ? tagOf(int'(exRtAddr), 1'b0) : forceTag, "exBVal", exBVal, expVal(s, exRtRf));
    s = expSel(int'(idRsAddr), 1'b1);
    chk(forceTag == "" ? tagOf(int'(idRsAddr), 1'b1) : forceTag, "idASel", DW'(idASel), DW'(s));
    chk(forceTag == "" ? tagOf(int'(idRsAddr), 1'b1) : forceTag, "idAVal", idAVal, expVal(s, idRsRf));
    s = expSel(int'(idRtAddr), 1'b1);
    chk(forceTag == "" ? tagOf(int'(idRtAddr), 1'b1) : forceTag, "idBSel", DW'(idBSel), DW'(s));
    chk(forceTag == "" ? tagOf(int'(idRtAddr), 1'b1) : forceTag, "idBVal", idBVal, expVal(s, idRtRf));
  endtask

  initial begin
    exRsRf = 16'h1111; exRtRf = 16'h2222; idRsRf = 16'h3333; idRtRf = 16'h4444;
    memAluRes = 16'hA0A0; wbAluRes = 16'hB0B0; wbLoadData = 16'hC0C0;
    exRsAddr = '0; exRtAddr = '0; idRsAddr = '0; idRtAddr = '0;
    memRd = '0; wbRd = '0; memRegWr = 0; memMemToReg = 0; wbRegWr = 0; wbMemToReg = 0;
    // idle state: everything from the register file (R11)
    checkAll("R11");

    // R8: operand A fed from EX/MEM, operand B from MEM/WB load in one cycle
    @(posedge clk);
    exRsAddr = 2'd1; exRtAddr = 2'd2; idRsAddr = 2'd3; idRtAddr = 2'd2;
    memRd = 2'd1; memRegWr = 1; memMemToReg = 0;
    wbRd = 2'd2; wbRegWr = 1; wbMemToReg = 1;
    checkAll("R8");

    // R5: both stages write the same register, EX/MEM wins
    @(posedge clk);
    exRsAddr = 2'd3; exRtAddr = 2'd3; idRsAddr = 2'd3; idRtAddr = 2'd0;
    memRd = 2'd3; wbRd = 2'd3; wbMemToReg = 0;
    checkAll("R5");

    // R6: writer to register zero is not forwarded
    @(posedge clk);
    exRsAddr = 2'd0; exRtAddr = 2'd0; idRsAddr = 2'd0; idRtAddr = 2'd0;
    memRd = 2'd0; wbRd = 2'd0;
    checkAll("R6");

    // exhaustive sweep over sources, destinations and flags
    for (int s = 0; s < 4; s++)
      for (int md = 0; md < 4; md++)
        for (int wd = 0; wd < 4; wd++)
          for (int f = 0; f < 16; f++) begin
            @(posedge clk);
            exRsAddr = AW'(s); exRtAddr = AW'(s + 1);
            idRsAddr = AW'(s); idRtAddr = AW'(s + 2);
            memRd = AW'(md); wbRd = AW'(wd);
            memRegWr = f[0]; memMemToReg = f[1]; wbRegWr = f[2]; wbMemToReg = f[3];
            checkAll("");
          end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule